// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine protects the data area of one NAND page with a line-and-column Hamming code. A page holds `NUM_CHUNKS` chunks of 512 bytes each. Every chunk gets its own 6-byte digest. The host streams the page data in one byte per cycle over a valid/ready input. It raises `start` beforehand, and `mode_read` chooses the direction.

In write mode, the engine emits the digests of all chunks back to back, in chunk order, over a valid/ready output. It then passes the page's `SPARE_FREE` free spare bytes from input to output unchanged. Together these form the spare area: digests first, free bytes after them.

In read mode, the host follows the page data with the stored digests, 6 bytes per chunk. After each chunk's sixth digest byte, the engine reports that chunk's status. When one data bit is in error, it also reports the byte offset and bit index to flip.

The control is a state machine with six states:
- IDLE waits for `start`. IDLE→LOAD on `start`.
- LOAD takes in page data. LOAD→WRITE_DIGEST after the last data byte in write mode. LOAD→READ_DIGEST after the last data byte in read mode.
- WRITE_DIGEST emits the digests. WRITE_DIGEST→SPARE_PASS after the last digest byte when `SPARE_FREE` > 0. Otherwise WRITE_DIGEST→FINISH.
- SPARE_PASS forwards the free spare bytes. SPARE_PASS→FINISH after the last spare byte.
- READ_DIGEST takes in the stored digests. READ_DIGEST→FINISH after the last byte of the last chunk's digest.
- FINISH raises `done` for one cycle. FINISH→IDLE always.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After synchronous reset, `in_ready`, `out_valid`, `stat_valid` and `done` are all 0.
- R2: In write mode, after the last data byte, the engine emits `NUM_CHUNKS`×6 digest bytes in chunk order. Digest byte k carries code bits [8k+7:8k] for k = 0..2, and bytes 3..5 are 0xFF.
- R3: The 24-bit code of a chunk is defined as follows. Offsets are counted from 0 within the chunk, and byte parity is the XOR of the byte's 8 bits.
  - Bit i (i = 0..8) is the XOR of the parity of every byte whose offset has bit i set.
  - Bit 9+i is the same XOR over bytes whose offset has bit i clear.
  - Bit 18+k (k = 0..2) is the XOR of every data bit whose bit index has bit k set.
  - Bit 21+k is the same XOR over data bits whose bit index has bit k clear.
- R4: After the digests, exactly `SPARE_FREE` input bytes reach the output unchanged, with `in_ready` equal to `out_ready`.
- R5: While a digest byte is offered and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R6: In read mode, a chunk whose data and stored digest agree reports `stat_kind` 0 (clean).
- R7: A single flipped data bit in a chunk reports `stat_kind` 1, with `fix_ofs` giving its byte offset and `fix_bit` giving its bit index.
- R8: A single flipped bit in stored digest bytes 0..2 reports `stat_kind` 2. Whenever `stat_kind` is not 1, `fix_ofs` and `fix_bit` are 0.
- R9: Two flipped data bits in one chunk report `stat_kind` 3 (uncorrectable).
- R10: In read mode, stored digest bytes 3..5 have no effect on the status.
- R11: `stat_valid` pulses in the cycle after the sixth digest byte of a chunk is accepted, with `stat_chunk` naming that chunk. `done` pulses once per page, in the cycle after the page's final accepted or forwarded byte.
- R12: `start` is ignored while a page is in progress, and `in_ready` is 0 in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a page, sampled in IDLE only |
| mode_read | input | 1 | 1 = read/check the page, 0 = write/generate digests |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte: data, then digests (read) or free spare bytes (write) |
| in_ready | output | 1 | Engine accepts the input byte |
| out_valid | output | 1 | Output byte valid (write mode) |
| out_data | output | 8 | Digest or forwarded spare byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| stat_valid | output | 1 | One-cycle chunk status strobe |
| stat_chunk | output | CHW | Chunk index of the status |
| stat_kind | output | 2 | 0 clean, 1 corrected, 2 digest error, 3 uncorrectable |
| fix_ofs | output | 9 | Byte offset of the failing bit |
| fix_bit | output | 3 | Bit index of the failing bit |
| done | output | 1 | One-cycle end-of-page pulse |

## Verification
The hardest outcome to reach from the ports is a syndrome with exactly twelve bits set in complementary pairs, aimed at a chosen bit. That outcome needs a correct digest for data that then differs in one bit.

The bench computes each chunk's digest from the clean page. It then sends the page with chosen bits inverted. It sweeps offsets 0, 511 and every single-bit offset weight, across all eight bit positions, in both chunks.

Digest-only flips cover all 24 code bits. Paired flips cover the same byte, distant bytes and adjacent bytes, so the corrected and uncorrectable classes are separated at their edges.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
    localparam int NHE_OFS_W       = 9;
    localparam int NHE_CHUNK_BYTES = 1 << NHE_OFS_W;
    localparam int NHE_BIT_W       = 3;
    localparam int NHE_CODE_W      = 2 * (NHE_OFS_W + NHE_BIT_W);
    localparam int NHE_CODE_BYTES  = NHE_CODE_W / 8;
    localparam int NHE_DIG_BYTES   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WDIG,
        ST_SPARE,
        ST_RDIG,
        ST_FIN
    } nhe_state_t;

    typedef enum logic [1:0] {
        CK_CLEAN  = 2'd0,
        CK_FIXED  = 2'd1,
        CK_DIGEST = 2'd2,
        CK_FATAL  = 2'd3
    } nhe_kind_t;

    // Mask of the bit lanes whose index has bit k set.
    function automatic logic [7:0] nhe_lane_mask(input int k);
        logic [7:0] m;
        for (int j = 0; j < 8; j++) begin
            m[j] = ((j >> k) & 1) == 1;
        end
        return m;
    endfunction
endpackage

// File: rtl/nhe_parity_acc.sv
module nhe_parity_acc
    import nhe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  last,
    input  logic [7:0]            byte_i,
    input  logic [NHE_OFS_W-1:0]  ofs_i,
    output logic [NHE_CODE_W-1:0] code_o
);
    logic [7:0]           lane_q, lane_n;
    logic [NHE_OFS_W-1:0] line_q, line_n;
    logic                 total;

    always_comb begin
        lane_n = lane_q ^ (en ? byte_i : 8'h00);
        line_n = line_q ^ ((en && (^byte_i)) ? ofs_i : '0);
        total  = ^lane_n;
    end

    assign code_o[NHE_OFS_W-1:0]           = line_n;
    assign code_o[2*NHE_OFS_W-1:NHE_OFS_W] = line_n ^ {NHE_OFS_W{total}};

    for (genvar k = 0; k < NHE_BIT_W; k++) begin : g_lane
        localparam logic [7:0] HI = nhe_lane_mask(k);
        assign code_o[2*NHE_OFS_W+k]           = ^(lane_n & HI);
        assign code_o[2*NHE_OFS_W+NHE_BIT_W+k] = ^(lane_n & ~HI);
    end

    // Cleared at every chunk boundary so offsets stay chunk-relative.
    always_ff @(posedge clk) begin
        if (rst || (en && last)) begin
            lane_q <= '0;
            line_q <= '0;
        end else begin
            lane_q <= lane_n;
            line_q <= line_n;
        end
    end
endmodule

// File: rtl/nhe_syndrome.sv
module nhe_syndrome
    import nhe_pkg::*;
(
    input  logic [NHE_CODE_W-1:0] stored_i,
    input  logic [NHE_CODE_W-1:0] calc_i,
    output nhe_kind_t             kind_o,
    output logic [NHE_OFS_W-1:0]  fix_ofs_o,
    output logic [NHE_BIT_W-1:0]  fix_bit_o
);
    logic [NHE_CODE_W-1:0] syn;
    logic [NHE_OFS_W-1:0]  ln_hi, ln_lo;
    logic [NHE_BIT_W-1:0]  cl_hi, cl_lo;
    logic                  paired;

    always_comb begin
        syn    = stored_i ^ calc_i;
        ln_hi  = syn[NHE_OFS_W-1:0];
        ln_lo  = syn[2*NHE_OFS_W-1:NHE_OFS_W];
        cl_hi  = syn[2*NHE_OFS_W+NHE_BIT_W-1:2*NHE_OFS_W];
        cl_lo  = syn[NHE_CODE_W-1:2*NHE_OFS_W+NHE_BIT_W];
        paired = (&(ln_hi ^ ln_lo)) && (&(cl_hi ^ cl_lo));
        kind_o    = CK_FATAL;
        fix_ofs_o = '0;
        fix_bit_o = '0;
        if (syn == '0) begin
            kind_o = CK_CLEAN;
        end else if (paired) begin
            kind_o    = CK_FIXED;
            fix_ofs_o = ln_hi;
            fix_bit_o = cl_hi;
        end else if ($countones(syn) == 1) begin
            kind_o = CK_DIGEST;
        end
    end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
    import nhe_pkg::*;
#(
    parameter  int NUM_CHUNKS = 2,
    parameter  int SPARE_FREE = 10,
    localparam int CHW        = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           mode_read,
    input  logic           in_valid,
    input  logic [7:0]     in_data,
    output logic           in_ready,
    output logic           out_valid,
    output logic [7:0]     out_data,
    input  logic           out_ready,
    output logic           stat_valid,
    output logic [CHW-1:0] stat_chunk,
    output logic [1:0]     stat_kind,
    output logic [8:0]     fix_ofs,
    output logic [2:0]     fix_bit,
    output logic           done
);
    localparam int SPW     = (SPARE_FREE > 1) ? $clog2(SPARE_FREE) : 1;
    localparam int SP_LAST = (SPARE_FREE > 0) ? SPARE_FREE - 1 : 0;
    localparam int D_LAST  = NHE_DIG_BYTES - 1;

    nhe_state_t            state, nxt;
    logic                  mode_q;
    logic [NHE_OFS_W-1:0]  ofs_q;
    logic [CHW-1:0]        chunk_q;
    logic [2:0]            dbyte_q;
    logic [SPW-1:0]        spare_q;
    logic [NHE_CODE_W-1:0] code_mem [NUM_CHUNKS];
    logic [NHE_CODE_W-1:0] stored_q, acc_code, cur_code;
    logic                  acc_en, chunk_last, dig_last, spare_last;
    nhe_kind_t             dec_kind, kind_q;
    logic [NHE_OFS_W-1:0]  dec_ofs;
    logic [NHE_BIT_W-1:0]  dec_bit;

    assign acc_en     = (state == ST_LOAD) && in_valid;
    assign chunk_last = chunk_q == CHW'(NUM_CHUNKS - 1);
    assign dig_last   = dbyte_q == 3'(D_LAST);
    assign spare_last = spare_q == SPW'(SP_LAST);
    assign cur_code   = code_mem[chunk_q];

    nhe_parity_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (acc_en),
        .last   (&ofs_q),
        .byte_i (in_data),
        .ofs_i  (ofs_q),
        .code_o (acc_code)
    );

    nhe_syndrome u_syn (
        .stored_i  (stored_q),
        .calc_i    (cur_code),
        .kind_o    (dec_kind),
        .fix_ofs_o (dec_ofs),
        .fix_bit_o (dec_bit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LOAD;
            ST_LOAD:  if (in_valid && (&ofs_q) && chunk_last)
                          nxt = mode_q ? ST_RDIG : ST_WDIG;
            ST_WDIG:  if (out_ready && dig_last && chunk_last)
                          nxt = (SPARE_FREE > 0) ? ST_SPARE : ST_FIN;
            ST_SPARE: if (in_valid && out_ready && spare_last) nxt = ST_FIN;
            ST_RDIG:  if (in_valid && dig_last && chunk_last) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'hFF;
        done      = 1'b0;
        unique case (state)
            ST_LOAD, ST_RDIG: in_ready = 1'b1;
            ST_WDIG: begin
                out_valid = 1'b1;
                if (dbyte_q < 3'(NHE_CODE_BYTES))
                    out_data = 8'(cur_code >> {dbyte_q, 3'b000});
            end
            ST_SPARE: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    // Datapath counters and status
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= 1'b0;
            ofs_q      <= '0;
            chunk_q    <= '0;
            dbyte_q    <= '0;
            spare_q    <= '0;
            stored_q   <= '0;
            stat_valid <= 1'b0;
            stat_chunk <= '0;
            kind_q     <= CK_CLEAN;
            fix_ofs    <= '0;
            fix_bit    <= '0;
        end else begin
            stat_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q  <= mode_read;
                    ofs_q   <= '0;
                    chunk_q <= '0;
                    dbyte_q <= '0;
                    spare_q <= '0;
                end
                ST_LOAD: if (in_valid) begin
                    ofs_q <= ofs_q + 1'b1;
                    if (&ofs_q) chunk_q <= chunk_last ? '0 : chunk_q + 1'b1;
                end
                ST_WDIG: if (out_ready) begin
                    dbyte_q <= dig_last ? '0 : dbyte_q + 1'b1;
                    if (dig_last) chunk_q <= chunk_last ? '0 : chunk_q + 1'b1;
                end
                ST_SPARE: if (in_valid && out_ready) spare_q <= spare_q + 1'b1;
                ST_RDIG: if (in_valid) begin
                    if (dbyte_q < 3'(NHE_CODE_BYTES))
                        stored_q[{dbyte_q[1:0], 3'b000} +: 8] <= in_data;
                    dbyte_q <= dig_last ? '0 : dbyte_q + 1'b1;
                    if (dig_last) begin
                        chunk_q    <= chunk_last ? '0 : chunk_q + 1'b1;
                        stat_valid <= 1'b1;
                        stat_chunk <= chunk_q;
                        kind_q     <= dec_kind;
                        fix_ofs    <= dec_ofs;
                        fix_bit    <= dec_bit;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (acc_en && (&ofs_q)) code_mem[chunk_q] <= acc_code;
    end

    assign stat_kind = kind_q;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stat_valid && !done && !out_valid && !in_ready));

    a_r5_digest_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDIG && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r8_no_location: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_kind != 2'd1) |-> (fix_ofs == '0 && fix_bit == '0));

    a_r11_status_timing: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(state == ST_RDIG && in_valid && dbyte_q == 3'(D_LAST)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_idle_closed: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!in_ready && !out_valid));
endmodule

// File: tb/tb_nand_hamming_ecc.sv
module tb_nand_hamming_ecc;
    localparam int NC = 2;
    localparam int SF = 10;
    localparam int CB = 512;

    logic       clk = 1'b0;
    logic       rst, start, mode_read, in_valid, out_ready;
    logic [7:0] in_data;
    logic       in_ready, out_valid, stat_valid, done;
    logic [7:0] out_data;
    logic [0:0] stat_chunk;
    logic [1:0] stat_kind;
    logic [8:0] fix_ofs;
    logic [2:0] fix_bit;

    always #5 clk = ~clk;

    nand_hamming_ecc #(.NUM_CHUNKS(NC), .SPARE_FREE(SF)) dut (
        .clk(clk), .rst(rst), .start(start), .mode_read(mode_read),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .stat_valid(stat_valid), .stat_chunk(stat_chunk), .stat_kind(stat_kind),
        .fix_ofs(fix_ofs), .fix_bit(fix_bit), .done(done)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int last_fire = 0;
    logic bp_en = 1'b0;
    int bp_cnt = 0;
    logic [7:0] pg [NC*CB];

    int st_n = 0, done_n = 0, done_cyc = 0, cap_n = 0;
    int st_chunk [256], st_kind [256], st_ofs [256], st_bit [256], st_cyc [256];
    logic [7:0] cap [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (stat_valid) begin
            if (st_n < 256) begin
                st_chunk[st_n] = int'(stat_chunk);
                st_kind[st_n]  = int'(stat_kind);
                st_ofs[st_n]   = int'(fix_ofs);
                st_bit[st_n]   = int'(fix_bit);
                st_cyc[st_n]   = cyc;
            end
            st_n++;
        end
        if (done) begin
            done_n++;
            done_cyc = cyc;
        end
        if (out_valid && out_ready) begin
            if (cap_n < 64) cap[cap_n] = out_data;
            cap_n++;
        end
    end

    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = !bp_en || (bp_cnt % 3 != 0);
            bp_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int idx);
        return 8'((idx * 37) ^ (seed * 91) ^ ((idx >> 4) * 5) ^ (seed * idx));
    endfunction

    // Code by definition, one data bit at a time
    function automatic logic [23:0] ref_code(input int c);
        logic [23:0] r = '0;
        for (int a = 0; a < CB; a++)
            for (int b = 0; b < 8; b++)
                if (pg[c*CB + a][b]) begin
                    for (int i = 0; i < 9; i++)
                        if (((a >> i) & 1) == 1) r[i] = ~r[i]; else r[9+i] = ~r[9+i];
                    for (int k = 0; k < 3; k++)
                        if (((b >> k) & 1) == 1) r[18+k] = ~r[18+k]; else r[21+k] = ~r[21+k];
                end
        return r;
    endfunction

    function automatic int ofs_tab(input int k);
        if (k == 0) return 0;
        if (k == 10) return 511;
        return 1 << (k - 1);
    endfunction

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        last_fire = cyc;
        in_valid  = 1'b0;
    endtask

    task automatic do_start(input logic m);
        @(posedge clk);
        #1;
        start = 1'b1;
        mode_read = m;
        @(posedge clk);
        #1;
        start = 1'b0;
        mode_read = 1'b0;
    endtask

    task automatic write_page(input int seed, input logic bp, input logic inj);
        int cb = cap_n;
        int dn = done_n;
        int lf;
        string rq;
        logic [23:0] code;
        logic [7:0] e;
        rq = inj ? "R12" : (bp ? "R5" : "R2");
        for (int i = 0; i < NC*CB; i++) pg[i] = gen(seed, i);
        bp_en = bp;
        do_start(1'b0);
        for (int i = 0; i < NC*CB; i++) begin
            if (inj && i == 300) begin start = 1'b1; mode_read = 1'b1; end
            send(pg[i]);
            if (inj && i == 300) begin start = 1'b0; mode_read = 1'b0; end
        end
        for (int j = 0; j < SF; j++) send(gen(seed + 50, j));
        lf = last_fire;
        repeat (3) @(posedge clk);
        #1;
        bp_en = 1'b0;
        chk("R4", "output byte count", cap_n - cb, NC*6 + SF);
        for (int c = 0; c < NC; c++) begin
            code = ref_code(c);
            for (int j = 0; j < 6; j++) begin
                e = (j < 3) ? code[8*j +: 8] : 8'hFF;
                chk((j < 3) ? "R3" : rq, "digest byte", int'(cap[cb + c*6 + j]), int'(e));
            end
        end
        for (int j = 0; j < SF; j++)
            chk("R4", "spare byte", int'(cap[cb + NC*6 + j]), int'(gen(seed + 50, j)));
        chk("R11", "write done count", done_n - dn, 1);
        chk("R11", "write done cycle", done_cyc, lf);
    endtask

    task automatic read_page(input int seed, input int fa, input int fb,
                             input int da, input int db, input logic junk);
        int sb = st_n;
        int dn = done_n;
        int ecyc [NC];
        logic [23:0] rc [NC];
        logic [7:0] d;
        int nd, ng, eo, ebit, ek;
        string rq;
        for (int i = 0; i < NC*CB; i++) pg[i] = gen(seed, i);
        for (int c = 0; c < NC; c++) rc[c] = ref_code(c);
        do_start(1'b1);
        for (int i = 0; i < NC*CB; i++) begin
            d = pg[i];
            if (fa >= 0 && fa / 8 == i) d ^= 8'(1 << (fa % 8));
            if (fb >= 0 && fb / 8 == i) d ^= 8'(1 << (fb % 8));
            send(d);
        end
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < 6; j++) begin
                d = (j < 3) ? rc[c][8*j +: 8] : (junk ? 8'(j*29 + c*7 + 1) : 8'hFF);
                if (da >= 0 && da / 24 == c && (da % 24) / 8 == j) d ^= 8'(1 << (da % 8));
                if (db >= 0 && db / 24 == c && (db % 24) / 8 == j) d ^= 8'(1 << (db % 8));
                send(d);
                if (j == 5) ecyc[c] = last_fire;
            end
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "status count", st_n - sb, NC);
        for (int c = 0; c < NC; c++) begin
            nd = 0; ng = 0; eo = 0; ebit = 0;
            if (fa >= 0 && fa / 4096 == c) begin nd++; eo = (fa % 4096) / 8; ebit = fa % 8; end
            if (fb >= 0 && fb / 4096 == c) begin nd++; eo = (fb % 4096) / 8; ebit = fb % 8; end
            if (da >= 0 && da / 24 == c) ng++;
            if (db >= 0 && db / 24 == c) ng++;
            if (nd == 0 && ng == 0)      ek = 0;
            else if (nd == 1 && ng == 0) ek = 1;
            else if (nd == 0 && ng == 1) ek = 2;
            else                         ek = 3;
            if (ek != 1) begin eo = 0; ebit = 0; end
            case (ek)
                0: rq = junk ? "R10" : "R6";
                1: rq = "R7";
                2: rq = "R8";
                default: rq = "R9";
            endcase
            chk("R11", "status chunk", st_chunk[sb + c], c);
            chk("R11", "status cycle", st_cyc[sb + c], ecyc[c]);
            chk(rq, "status kind", st_kind[sb + c], ek);
            chk((ek == 1) ? "R7" : "R8", "fix offset", st_ofs[sb + c], eo);
            chk((ek == 1) ? "R7" : "R8", "fix bit", st_bit[sb + c], ebit);
        end
        chk("R11", "read done count", done_n - dn, 1);
        chk("R11", "read done cycle", done_cyc, ecyc[NC-1]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail + 1);
        $finish;
    end

    initial begin
        int sc, dc, cc;
        rst = 1'b1; start = 1'b0; mode_read = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "in_ready after reset", int'(in_ready), 0);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "stat_valid after reset", int'(stat_valid), 0);
        chk("R1", "done after reset", int'(done), 0);

        // Input offered in IDLE without start is refused
        sc = st_n; dc = done_n; cc = cap_n;
        in_valid = 1'b1; in_data = 8'hA5;
        repeat (5) @(negedge clk);
        chk("R12", "idle in_ready", int'(in_ready), 0);
        chk("R12", "idle produced nothing", (st_n - sc) + (done_n - dc) + (cap_n - cc), 0);
        in_valid = 1'b0;

        write_page(1, 1'b0, 1'b0);
        write_page(2, 1'b1, 1'b1);

        read_page(3, -1, -1, -1, -1, 1'b0);

        // Single data bit sweep: offsets 0, 511 and each offset weight, all bit lanes
        for (int p = 0; p < 44; p++) begin
            int ka = 2 * p;
            int kb = 2 * p + 1;
            read_page(10 + p,
                      ofs_tab(ka / 8) * 8 + (ka % 8),
                      4096 + ofs_tab(kb / 8) * 8 + (kb % 8),
                      -1, -1, 1'b0);
        end

        // Single digest bit sweep over all 24 code bits
        for (int q = 0; q < 12; q++)
            read_page(60 + q, -1, -1, q, 24 + (23 - q), 1'b0);

        // Double data bit errors
        read_page(80, 5*8 + 2, 5*8 + 6, -1, -1, 1'b0);
        read_page(81, 4096 + 0, 4096 + 511*8 + 7, -1, -1, 1'b0);
        read_page(82, 100*8 + 3, 101*8 + 3, -1, -1, 1'b0);
        read_page(83, 4096 + 256*8 + 1, 4096 + 255*8 + 1, -1, -1, 1'b0);

        // Non-0xFF filler in digest bytes 3..5
        read_page(90, -1, -1, -1, -1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule